// File: doc/BRIEF.md
# Burst SRAM Command and Address Sequencer

This block is the clocked front end of a synchronous burst SRAM. On every rising clock edge it samples an active-low and an active-high chip enable, a processor-side and a controller-side address strobe, a burst advance input, the write controls and the address bus. From these it classifies the cycle as one of five kinds: deselect, new read burst, new write burst, burst continue or burst suspend. It then produces a registered array address, a per-lane write-enable vector, a read strobe and a deselect strobe for the memory core behind it.

A new burst loads the full external address, and its two low bits seed a two-bit beat counter. Continue cycles step the counter, and the low address bits follow either a linear (modulo-4 increment) or an interleaved (XOR with the beat number) order. The order is chosen by a static mode input. A burst started by the processor-side strobe is always a read. A burst started by the controller-side strobe is a read or a write depending on the write controls. Lane count and address width are parameters.

All outputs are registered. A command sampled at clock edge k appears on the outputs just after edge k and holds until edge k+1.

Top module: `bsram_cmd_ctrl`

## Requirements
- R1: With `cs_n_i` high and `strb_ctl_n_i` low, the cycle is a deselect whatever `strb_proc_n_i` is. A deselect gives `desel_o`=1, `rd_o`=0, `we_o`=0, leaves `arr_addr_o` unchanged and ends any burst.
- R2: With `cs_n_i` low and `cs_i` low, the cycle is a deselect if `strb_proc_n_i` is low, or if `strb_proc_n_i` is high and `strb_ctl_n_i` is low.
- R3: With `cs_n_i` low, `cs_i` high and `strb_proc_n_i` low, a read burst starts: `arr_addr_o`=`addr_i`, `rd_o`=1, `we_o`=0, whatever the write controls are.
- R4: With both enables true, `strb_proc_n_i` high and `strb_ctl_n_i` low, a burst starts at `addr_i`. It is a write if the lane mask of R8 is non-zero (`we_o`=mask, `rd_o`=0), otherwise a read.
- R5: With `strb_ctl_n_i` high and either `strb_proc_n_i` high or `cs_n_i` high, during a burst: `adv_n_i` low steps the beat counter and repeats the burst's read/write type. `adv_n_i` high repeats the access at the unchanged address. A write beat takes its lanes from the current write controls.
- R6: With `order_sel_i`=0 (linear), beat k of a burst starting at low bits s has `arr_addr_o[1:0]`=(s+k) mod 4. The upper address bits stay those of the start address.
- R7: With `order_sel_i`=1 (interleaved), beat k has `arr_addr_o[1:0]`=s XOR k. In both orders the fifth beat returns to s.
- R8: Lane mask: `all_wr_n_i` low enables every present lane. Otherwise `byte_wr_n_i` low enables exactly the lanes i with `byte_sel_n_i[i]` low. Otherwise the mask is empty.
- R9: A new burst may start on every cycle, back to back, with no idle cycle between bursts.
- R10: Lanes at index `USED_LANES` and above are never write-enabled, and their select inputs are ignored.
- R11: Synchronous reset gives `arr_addr_o`=0, `rd_o`=0, `we_o`=0, `desel_o`=1 and no burst. A continue or suspend cycle with no burst active is a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| cs_n_i | input | 1 | Chip enable, active low |
| cs_i | input | 1 | Chip enable, active high |
| strb_proc_n_i | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n_i | input | 1 | Controller-side address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| all_wr_n_i | input | 1 | Write all lanes, active low |
| byte_wr_n_i | input | 1 | Lane write qualifier, active low |
| byte_sel_n_i | input | MAX_LANES | Per-lane write select, active low |
| addr_i | input | ADDR_W | External address |
| order_sel_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| arr_addr_o | output | ADDR_W | Array address for this cycle |
| we_o | output | MAX_LANES | Per-lane write enable |
| rd_o | output | 1 | Read access this cycle |
| desel_o | output | 1 | Deselect cycle |

## Verification
Bursts are started from seed low bits 2 and 1 and advanced past four beats under both orders. This separates a modulo-4 increment from an XOR sequence and shows the wrap on the fifth beat. Each strobe/enable combination is applied with the write controls asserted, so a processor-strobe start that wrongly writes stands apart from a controller-strobe start that must write. Continue and suspend are sent both inside a burst and while idle. A two-lane copy of the block is driven in parallel, and a write that selects only an upper lane must become a read there. Long runs of random stimulus then compare every output to a behavioural model on every clock.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  typedef enum logic [2:0] {
    CMD_DESEL    = 3'd0,
    CMD_START_RD = 3'd1,
    CMD_START_WR = 3'd2,
    CMD_CONT     = 3'd3,
    CMD_HOLD     = 3'd4
  } cmd_e;
endpackage

// File: rtl/bsram_lane_mask.sv
module bsram_lane_mask #(
  parameter int MAX_LANES  = 4,
  parameter int USED_LANES = 4
) (
  input  logic                 all_wr_n_i,
  input  logic                 byte_wr_n_i,
  input  logic [MAX_LANES-1:0] byte_sel_n_i,
  output logic [MAX_LANES-1:0] mask_o
);
  // Present lanes follow the write controls; absent lanes are tied off.
  for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
    if (g < USED_LANES) begin : g_used
      assign mask_o[g] = ~all_wr_n_i | (~byte_wr_n_i & ~byte_sel_n_i[g]);
    end else begin : g_absent
      assign mask_o[g] = 1'b0;
    end
  end
endmodule

// File: rtl/bsram_cmd_decode.sv
module bsram_cmd_decode
  import bsram_pkg::*;
#(
  parameter int MAX_LANES  = 4,
  parameter int USED_LANES = 4
) (
  input  logic                 cs_n_i,
  input  logic                 cs_i,
  input  logic                 strb_proc_n_i,
  input  logic                 strb_ctl_n_i,
  input  logic                 adv_n_i,
  input  logic                 all_wr_n_i,
  input  logic                 byte_wr_n_i,
  input  logic [MAX_LANES-1:0] byte_sel_n_i,
  output cmd_e                 cmd_o,
  output logic [MAX_LANES-1:0] lane_mask_o
);
  logic sel_both;

  bsram_lane_mask #(
    .MAX_LANES (MAX_LANES),
    .USED_LANES(USED_LANES)
  ) u_mask (
    .all_wr_n_i  (all_wr_n_i),
    .byte_wr_n_i (byte_wr_n_i),
    .byte_sel_n_i(byte_sel_n_i),
    .mask_o      (lane_mask_o)
  );

  assign sel_both = ~cs_n_i & cs_i;

  // Priority: processor strobe start, controller strobe start,
  // deselect forms, then continue or suspend.
  always_comb begin
    if (sel_both && !strb_proc_n_i) begin
      cmd_o = CMD_START_RD;
    end else if (sel_both && !strb_ctl_n_i) begin
      cmd_o = (|lane_mask_o) ? CMD_START_WR : CMD_START_RD;
    end else if (!strb_ctl_n_i) begin
      cmd_o = CMD_DESEL;
    end else if (!cs_n_i && !strb_proc_n_i) begin
      cmd_o = CMD_DESEL;
    end else if (adv_n_i) begin
      cmd_o = CMD_HOLD;
    end else begin
      cmd_o = CMD_CONT;
    end
  end
endmodule

// File: rtl/bsram_burst_addr.sv
module bsram_burst_addr #(
  parameter int ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [ADDR_W-1:0] nxt_addr_o
);
  localparam int CNT_W = 2;

  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_nxt;

  function automatic logic [CNT_W-1:0] beat_lo(
    input logic [CNT_W-1:0] seed,
    input logic [CNT_W-1:0] beat,
    input logic             ilv
  );
    return ilv ? (seed ^ beat) : CNT_W'(seed + beat);
  endfunction

  assign cnt_nxt = CNT_W'(cnt_q + 1'b1);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      base_q <= addr_i;
      cnt_q  <= '0;
    end else if (step_i) begin
      cnt_q  <= cnt_nxt;
    end
  end

  assign cur_addr_o = {base_q[ADDR_W-1:CNT_W], beat_lo(base_q[CNT_W-1:0], cnt_q, order_i)};
  assign nxt_addr_o = {base_q[ADDR_W-1:CNT_W], beat_lo(base_q[CNT_W-1:0], cnt_nxt, order_i)};
endmodule

// File: rtl/bsram_cmd_ctrl.sv
module bsram_cmd_ctrl
  import bsram_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int MAX_LANES  = 4,
  parameter int USED_LANES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 cs_n_i,
  input  logic                 cs_i,
  input  logic                 strb_proc_n_i,
  input  logic                 strb_ctl_n_i,
  input  logic                 adv_n_i,
  input  logic                 all_wr_n_i,
  input  logic                 byte_wr_n_i,
  input  logic [MAX_LANES-1:0] byte_sel_n_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 order_sel_i,
  output logic [ADDR_W-1:0]    arr_addr_o,
  output logic [MAX_LANES-1:0] we_o,
  output logic                 rd_o,
  output logic                 desel_o
);
  cmd_e                 cmd_raw;
  cmd_e                 cmd_eff;
  logic [MAX_LANES-1:0] lane_mask;
  logic [ADDR_W-1:0]    cur_addr;
  logic [ADDR_W-1:0]    nxt_addr;
  logic                 active_q;
  logic                 wr_q;

  bsram_cmd_decode #(
    .MAX_LANES (MAX_LANES),
    .USED_LANES(USED_LANES)
  ) u_dec (
    .cs_n_i       (cs_n_i),
    .cs_i         (cs_i),
    .strb_proc_n_i(strb_proc_n_i),
    .strb_ctl_n_i (strb_ctl_n_i),
    .adv_n_i      (adv_n_i),
    .all_wr_n_i   (all_wr_n_i),
    .byte_wr_n_i  (byte_wr_n_i),
    .byte_sel_n_i (byte_sel_n_i),
    .cmd_o        (cmd_raw),
    .lane_mask_o  (lane_mask)
  );

  // A continue or suspend with no burst in flight falls back to deselect.
  always_comb begin
    cmd_eff = cmd_raw;
    if ((cmd_raw == CMD_CONT || cmd_raw == CMD_HOLD) && !active_q) begin
      cmd_eff = CMD_DESEL;
    end
  end

  bsram_burst_addr #(
    .ADDR_W(ADDR_W)
  ) u_burst (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .load_i    (cmd_eff == CMD_START_RD || cmd_eff == CMD_START_WR),
    .step_i    (cmd_eff == CMD_CONT),
    .order_i   (order_sel_i),
    .addr_i    (addr_i),
    .cur_addr_o(cur_addr),
    .nxt_addr_o(nxt_addr)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      active_q   <= 1'b0;
      wr_q       <= 1'b0;
      arr_addr_o <= '0;
      we_o       <= '0;
      rd_o       <= 1'b0;
      desel_o    <= 1'b1;
    end else begin
      case (cmd_eff)
        CMD_START_RD: begin
          active_q   <= 1'b1;
          wr_q       <= 1'b0;
          arr_addr_o <= addr_i;
          we_o       <= '0;
          rd_o       <= 1'b1;
          desel_o    <= 1'b0;
        end
        CMD_START_WR: begin
          active_q   <= 1'b1;
          wr_q       <= 1'b1;
          arr_addr_o <= addr_i;
          we_o       <= lane_mask;
          rd_o       <= 1'b0;
          desel_o    <= 1'b0;
        end
        CMD_CONT, CMD_HOLD: begin
          arr_addr_o <= (cmd_eff == CMD_CONT) ? nxt_addr : cur_addr;
          we_o       <= wr_q ? lane_mask : '0;
          rd_o       <= ~wr_q;
          desel_o    <= 1'b0;
        end
        default: begin
          active_q   <= 1'b0;
          we_o       <= '0;
          rd_o       <= 1'b0;
          desel_o    <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/bsram_cmd_ctrl_chk.sv
module bsram_cmd_ctrl_chk #(
  parameter int ADDR_W     = 19,
  parameter int MAX_LANES  = 4,
  parameter int USED_LANES = 4
) (
  input logic                 clk_i,
  input logic                 rst_i,
  input logic                 cs_n_i,
  input logic                 cs_i,
  input logic                 strb_proc_n_i,
  input logic                 strb_ctl_n_i,
  input logic                 adv_n_i,
  input logic                 all_wr_n_i,
  input logic                 byte_wr_n_i,
  input logic [MAX_LANES-1:0] byte_sel_n_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic                 order_sel_i,
  input logic [ADDR_W-1:0]    arr_addr_o,
  input logic [MAX_LANES-1:0] we_o,
  input logic                 rd_o,
  input logic                 desel_o
);
  logic [MAX_LANES-1:0] used_mask;
  logic                 ctl_start;
  logic                 idle_cmd;

  always_comb begin
    for (int i = 0; i < MAX_LANES; i++) used_mask[i] = (i < USED_LANES);
  end

  assign ctl_start = !cs_n_i && cs_i && strb_proc_n_i && !strb_ctl_n_i;
  assign idle_cmd  = strb_ctl_n_i && (strb_proc_n_i || cs_n_i);

  AST_OFF_DESEL: assert property (@(posedge clk_i) disable iff (rst_i)
    (cs_n_i && !strb_ctl_n_i) |=> (desel_o && !rd_o && we_o == '0)); // R1

  AST_HALF_EN_DESEL: assert property (@(posedge clk_i) disable iff (rst_i)
    (!cs_n_i && !cs_i && (!strb_proc_n_i || !strb_ctl_n_i)) |=> desel_o); // R2

  AST_PROC_STROBE_READ: assert property (@(posedge clk_i) disable iff (rst_i)
    (!cs_n_i && cs_i && !strb_proc_n_i) |=> (rd_o && we_o == '0 && arr_addr_o == $past(addr_i))); // R3

  AST_RD_WE_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_o |-> (we_o == '0 && !desel_o)); // R4

  AST_SUSPEND_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (idle_cmd && adv_n_i && !desel_o) |=> (!desel_o && $stable(arr_addr_o))); // R5

  AST_LINEAR_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    (idle_cmd && !adv_n_i && !desel_o && !order_sel_i) |=>
      (arr_addr_o[1:0] == 2'($past(arr_addr_o[1:0]) + 2'd1) &&
       arr_addr_o[ADDR_W-1:2] == $past(arr_addr_o[ADDR_W-1:2]))); // R6

  AST_GLOBAL_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
    (ctl_start && !all_wr_n_i) |=> (we_o == used_mask && !rd_o)); // R8

  AST_BYTE_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
    (ctl_start && all_wr_n_i && !byte_wr_n_i) |=> (we_o == (~$past(byte_sel_n_i) & used_mask))); // R8
endmodule

bind bsram_cmd_ctrl bsram_cmd_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .MAX_LANES (MAX_LANES),
  .USED_LANES(USED_LANES)
) u_chk (.*);

// File: tb/test_bsram_cmd_ctrl.sv
module test_bsram_cmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;
  localparam int ML = 4;

  logic clk = 1'b0;
  logic rst;
  logic cs_n, cs, adsp_n, adsc_n, adv_n, gw_n, bw_n, ord;
  logic [ML-1:0] sel_n;
  logic [AW-1:0] addr;
  logic [AW-1:0] a_w, a_n;
  logic [ML-1:0] we_w, we_n;
  logic rd_w, rd_n, ds_w, ds_n;

  int checks = 0;
  int failures = 0;

  // model state, index 0 = four-lane, index 1 = two-lane
  int m_active[2], m_wr[2], m_base[2], m_k[2], m_addr[2], m_rd[2], m_we[2], m_ds[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  bsram_cmd_ctrl #(.ADDR_W(AW), .MAX_LANES(ML), .USED_LANES(4)) i_bsram_cmd_ctrl (
    .clk_i(clk), .rst_i(rst), .cs_n_i(cs_n), .cs_i(cs), .strb_proc_n_i(adsp_n),
    .strb_ctl_n_i(adsc_n), .adv_n_i(adv_n), .all_wr_n_i(gw_n), .byte_wr_n_i(bw_n),
    .byte_sel_n_i(sel_n), .addr_i(addr), .order_sel_i(ord),
    .arr_addr_o(a_w), .we_o(we_w), .rd_o(rd_w), .desel_o(ds_w));

  bsram_cmd_ctrl #(.ADDR_W(AW), .MAX_LANES(ML), .USED_LANES(2)) i_bsram_cmd_ctrl_narrow (
    .clk_i(clk), .rst_i(rst), .cs_n_i(cs_n), .cs_i(cs), .strb_proc_n_i(adsp_n),
    .strb_ctl_n_i(adsc_n), .adv_n_i(adv_n), .all_wr_n_i(gw_n), .byte_wr_n_i(bw_n),
    .byte_sel_n_i(sel_n), .addr_i(addr), .order_sel_i(ord),
    .arr_addr_o(a_n), .we_o(we_n), .rd_o(rd_n), .desel_o(ds_n));

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R11 watchdog expired actual=running expected=finished");
    summary();
  end

  function automatic int lanes(input int used);
    int full = (1 << used) - 1;
    if (!gw_n) return full;
    if (!bw_n) return int'(~sel_n) & full;
    return 0;
  endfunction

  function automatic int beat_low(input int seed, input int k, input logic ilv);
    if (ilv) return seed ^ k;
    return (seed + k) % 4;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_active[i] = 0; m_wr[i] = 0; m_base[i] = 0; m_k[i] = 0;
      m_addr[i] = 0; m_rd[i] = 0; m_we[i] = 0; m_ds[i] = 1;
    end
  endtask

  task automatic model_step();
    for (int i = 0; i < 2; i++) begin
      int mask = lanes(i == 0 ? 4 : 2);
      int wr;
      if (!cs_n && cs && (!adsp_n || !adsc_n)) begin
        wr = (adsp_n && mask != 0) ? 1 : 0;
        m_active[i] = 1; m_wr[i] = wr; m_base[i] = int'(addr); m_k[i] = 0;
        m_addr[i] = int'(addr); m_rd[i] = 1 - wr; m_we[i] = wr ? mask : 0; m_ds[i] = 0;
      end else if (!adsc_n || (!cs_n && !adsp_n) || m_active[i] == 0) begin
        m_active[i] = 0; m_rd[i] = 0; m_we[i] = 0; m_ds[i] = 1;
      end else begin
        if (!adv_n) m_k[i] = (m_k[i] + 1) % 4;
        m_addr[i] = (m_base[i] & ~3) | beat_low(m_base[i] & 3, m_k[i], ord);
        m_rd[i] = 1 - m_wr[i]; m_we[i] = m_wr[i] ? m_we_mask(mask, i) : 0; m_ds[i] = 0;
      end
    end
  endtask

  function automatic int m_we_mask(input int mask, input int i);
    return (i >= 0) ? mask : 0;
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (int'(a_w) != m_addr[0] || int'(we_w) != m_we[0] || int'(rd_w) != m_rd[0] || int'(ds_w) != m_ds[0]) begin
      failures++;
      $display("FAIL %s wide actual addr=%h we=%b rd=%b ds=%b expected addr=%h we=%b rd=%0d ds=%0d",
               tag, a_w, we_w, rd_w, ds_w, m_addr[0][AW-1:0], m_we[0][ML-1:0], m_rd[0], m_ds[0]);
    end
    checks++;
    if (int'(a_n) != m_addr[1] || int'(we_n) != m_we[1] || int'(rd_n) != m_rd[1] || int'(ds_n) != m_ds[1]) begin
      failures++;
      $display("FAIL %s narrow actual addr=%h we=%b rd=%b ds=%b expected addr=%h we=%b rd=%0d ds=%0d",
               tag, a_n, we_n, rd_n, ds_n, m_addr[1][AW-1:0], m_we[1][ML-1:0], m_rd[1], m_ds[1]);
    end
  endtask

  // Drive at a falling edge, let one rising edge sample, compare at the next falling edge.
  task automatic cyc(input string tag, input logic c_n, input logic c, input logic p_n,
                     input logic s_n, input logic v_n, input logic g_n, input logic b_n,
                     input logic [ML-1:0] bs_n, input logic [AW-1:0] a, input logic o);
    cs_n = c_n; cs = c; adsp_n = p_n; adsc_n = s_n; adv_n = v_n;
    gw_n = g_n; bw_n = b_n; sel_n = bs_n; addr = a; ord = o;
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  // shorthands: controller start, processor start, continue, suspend
  task automatic ctl_go(input string t, input logic [AW-1:0] a, input logic o,
                        input logic g_n, input logic b_n, input logic [ML-1:0] bs_n);
    cyc(t, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, g_n, b_n, bs_n, a, o);
  endtask

  task automatic adv(input string t, input logic o, input logic g_n, input logic b_n,
                     input logic [ML-1:0] bs_n);
    cyc(t, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, g_n, b_n, bs_n, '0, o);
  endtask

  task automatic hold(input string t, input logic o);
    cyc(t, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '1, '0, o);
  endtask

  initial begin
    rst = 1'b1; cs_n = 1'b1; cs = 1'b0; adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bw_n = 1'b1; sel_n = '1; addr = '0; ord = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    compare("R11 reset");
    rst = 1'b0;

    // R11: continue and suspend while idle are deselects
    adv("R11 idle continue", 1'b0, 1'b1, 1'b1, '1);
    hold("R11 idle suspend", 1'b0);

    // R5 R6: linear burst seeded at 2, wraps on the fifth beat
    ctl_go("R6 linear start", 19'h12342, 1'b0, 1'b1, 1'b1, '1);
    for (int k = 0; k < 5; k++) adv("R6 linear beat", 1'b0, 1'b1, 1'b1, '1);
    hold("R5 suspend", 1'b0);
    hold("R5 suspend again", 1'b0);
    adv("R5 continue after suspend", 1'b0, 1'b1, 1'b1, '1);

    // R7: interleaved burst seeded at 1
    ctl_go("R7 interleaved start", 19'h0abc5, 1'b1, 1'b1, 1'b1, '1);
    for (int k = 0; k < 5; k++) adv("R7 interleaved beat", 1'b1, 1'b1, 1'b1, '1);

    // R4 R8: controller strobe write with lane select 4'b1010 (lanes 0 and 2)
    ctl_go("R4 byte write start", 19'h00103, 1'b0, 1'b1, 1'b0, 4'b1010);
    adv("R8 global write beat", 1'b0, 1'b0, 1'b1, 4'b1111);
    adv("R8 empty lane beat", 1'b0, 1'b1, 1'b1, 4'b0000);
    ctl_go("R8 bw high is read", 19'h00200, 1'b0, 1'b1, 1'b1, 4'b0000);

    // R3: processor strobe with global write low is still a read
    cyc("R3 proc start read", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0000, 19'h04444, 1'b0);

    // R1 and R2 deselect forms, with a burst active beforehand
    cyc("R1 off desel", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 19'h11111, 1'b0);
    adv("R11 continue after desel", 1'b0, 1'b1, 1'b1, '1);
    ctl_go("R9 restart", 19'h22222, 1'b0, 1'b1, 1'b1, '1);
    cyc("R2 half enable proc", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, '1, 19'h33333, 1'b0);
    ctl_go("R9 restart", 19'h22223, 1'b0, 1'b1, 1'b1, '1);
    cyc("R2 half enable ctl", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, '1, 19'h33333, 1'b0);
    cyc("R5 cs_n high continue idle", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, '1, '0, 1'b0);

    // R5: continue accepted with cs_n high during a burst
    ctl_go("R9 restart", 19'h50001, 1'b0, 1'b1, 1'b1, '1);
    cyc("R5 cs_n high continue", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, '1, '0, 1'b0);

    // R9: back-to-back starts, alternating reads and writes
    ctl_go("R9 back to back", 19'h60000, 1'b0, 1'b0, 1'b1, '1);
    ctl_go("R9 back to back", 19'h60010, 1'b0, 1'b1, 1'b1, '1);
    cyc("R9 back to back proc", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '1, 19'h60020, 1'b0);
    ctl_go("R9 back to back", 19'h60030, 1'b0, 1'b1, 1'b0, 4'b1100);

    // R10: only lane 3 selected -> write on four lanes, read on two lanes
    ctl_go("R10 upper lane only", 19'h70000, 1'b0, 1'b1, 1'b0, 4'b0111);
    adv("R10 upper lane beat", 1'b0, 1'b1, 1'b0, 4'b0011);
    ctl_go("R10 global write lanes", 19'h70004, 1'b0, 1'b0, 1'b1, '1);

    // R9: random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r = $urandom;
      cyc("R9 random", r[0] & r[1], r[2] | r[3], r[4] | r[5], r[6] | r[7], r[8], r[9] | r[10],
          r[11], r[15:12], AW'($urandom), r[16]);
    end
    summary();
  end
endmodule